// File: doc/BRIEF.md
# Pointer-Pair Register File

This block holds the thirty-two 8-bit working registers of a small 8-bit processor. Two independent byte read ports feed the operand paths. The first read port also returns the aligned register pair that contains its index, as one 16-bit value. A single write port stores either one byte or an aligned 16-bit pair in one clock. All reads are combinational and return the contents from before any write in the same cycle.

The six highest registers form three 16-bit address pointers. In each pointer the lower-numbered register holds the low byte. A pointer port selects one pointer and one addressing mode, and returns the effective address at once. In the post-increment and pre-decrement modes it also writes the adjusted pointer back at the clock edge. A separate byte port maps the whole file into data addresses 0x0000 to 0x001F. A pointer that holds such an address therefore reaches the registers themselves.

Top module: `rf_ptr_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0x00.
- R2: `rd_a_data_o` and `rd_b_data_o` return the registers indexed by `rd_a_idx_i` and `rd_b_idx_i`. `rd_pair_o` returns {register idx|1, register idx&~1} for `rd_a_idx_i`. All three are combinational and show the value from before any write in the same cycle.
- R3: When `wr_en_i`=1 and `wr_wide_i`=0, `wr_data_i[7:0]` is written to register `wr_idx_i`.
- R4: When `wr_en_i`=1 and `wr_wide_i`=1, `wr_data_i[7:0]` is written to register `wr_idx_i` with bit 0 cleared, and `wr_data_i[15:8]` is written to that register with bit 0 set.
- R5: Pointer select 0 picks registers 26/27, 1 picks 28/29 and 2 picks 30/31, with the low byte in the even register. Select 3 drives `ptr_addr_o` to 0 and updates nothing.
- R6: Mode 1 (post-increment) gives the current pointer as the address. When `ptr_en_i`=1 it stores the pointer plus 1, modulo 2^16.
- R7: Mode 2 (pre-decrement) gives the pointer minus 1, modulo 2^16, as the address. When `ptr_en_i`=1 it stores that value.
- R8: Mode 0 gives the pointer unchanged. Mode 3 gives the pointer plus the zero-extended 6-bit `ptr_disp_i`, modulo 2^16, for selects 1 and 2, and ignores the displacement for select 0. Neither mode changes the pointer.
- R9: With `mm_en_i`=1, `mm_hit_o` is 1 exactly when `mm_addr_i` < 0x20. On a hit, `mm_rdata_o` is register `mm_addr_i`; otherwise it is 0x00. A write (`mm_we_i`=1) takes effect only on a hit.
- R10: When several sources write the same register in one cycle, the write port wins over a pointer update, and a pointer update wins over a mapped write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Index for read port A |
| rd_a_data_o | output | 8 | Byte at index A |
| rd_pair_o | output | 16 | Aligned pair containing index A |
| rd_b_idx_i | input | 5 | Index for read port B |
| rd_b_data_o | output | 8 | Byte at index B |
| wr_en_i | input | 1 | Write port enable |
| wr_wide_i | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_idx_i | input | 5 | Write index |
| wr_data_i | input | 16 | Write data (byte writes use bits 7:0) |
| ptr_en_i | input | 1 | Allow pointer write-back |
| ptr_sel_i | input | 2 | Pointer select |
| ptr_mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_disp_i | input | 6 | Unsigned displacement |
| ptr_addr_o | output | 16 | Effective address |
| mm_en_i | input | 1 | Mapped access enable |
| mm_we_i | input | 1 | Mapped write |
| mm_addr_i | input | 16 | Data-space address |
| mm_wdata_i | input | 8 | Mapped write data |
| mm_hit_o | output | 1 | Address falls inside the register window |
| mm_rdata_o | output | 8 | Mapped read data |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, 16-bit pointers and a 6-bit displacement. With these values both pointer wrap points (0xFFFF to 0x0000 and back) can be reached in a single step, and so can the largest displacement added near the top of the address range. The 0x0020 address sits right above the register window, so a mapped access there shows that the decode compares the full address and not only its low five bits. Random traffic puts the write port, a pointer update and a mapped write on one register in the same cycle, which exercises the per-byte priority.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;
endpackage

// File: rtl/rf_ptr_unit.sv
module rf_ptr_unit
  import rf_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_PTRS     = 3,
  parameter int DISP_W       = 6,
  parameter int DISP_MIN_SEL = 1,
  localparam int SEL_W       = $clog2(NUM_PTRS + 1)
) (
  input  logic [NUM_PTRS*ADDR_W-1:0] ptr_vals_i,
  input  logic                       en_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  ptr_mode_e                  mode_i,
  input  logic [DISP_W-1:0]          disp_i,
  output logic [ADDR_W-1:0]          addr_o,
  output logic                       upd_o,
  output logic [SEL_W-1:0]           upd_sel_o,
  output logic [ADDR_W-1:0]          upd_val_o
);
  logic              valid;
  logic [ADDR_W-1:0] cur;

  assign valid     = (sel_i < SEL_W'(NUM_PTRS));
  assign upd_sel_o = sel_i;

  always_comb begin
    cur       = valid ? ptr_vals_i[sel_i*ADDR_W +: ADDR_W] : '0;
    addr_o    = cur;
    upd_o     = 1'b0;
    upd_val_o = cur;
    unique case (mode_i)
      PM_PLAIN: ;
      PM_POSTINC: begin
        upd_val_o = cur + ADDR_W'(1);
        upd_o     = en_i && valid;
      end
      PM_PREDEC: begin
        upd_val_o = cur - ADDR_W'(1);
        addr_o    = upd_val_o;
        upd_o     = en_i && valid;
      end
      PM_DISP: begin
        // displacement applies only to the upper pointers
        if (sel_i >= SEL_W'(DISP_MIN_SEL)) addr_o = cur + ADDR_W'(disp_i);
      end
      default: ;
    endcase
    if (!valid) addr_o = '0;
  end
endmodule

// File: rtl/rf_mmap_decode.sv
module rf_mmap_decode #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign hit_o = en_i && (addr_i < ADDR_W'(NUM_REGS));
  assign we_o  = hit_o && we_i;
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int SEL_W   = $clog2(NUM_PTRS + 1),
  localparam int PAIR_W  = 2 * DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       wr_wide_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [PAIR_W-1:0]          wr_data_i,
  input  logic                       ptr_upd_i,
  input  logic [SEL_W-1:0]           ptr_sel_i,
  input  logic [PAIR_W-1:0]          ptr_val_i,
  input  logic                       mm_we_i,
  input  logic [IDX_W-1:0]           mm_idx_i,
  input  logic [DATA_W-1:0]          mm_wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int HALF = i % 2;
    logic [DATA_W-1:0] q, d;
    logic              ptr_hit, wr_hit;

    if (i >= PTR_BASE && (i - PTR_BASE) / 2 < NUM_PTRS) begin : g_ptr
      assign ptr_hit = ptr_upd_i && (ptr_sel_i == SEL_W'((i - PTR_BASE) / 2));
    end else begin : g_plain
      assign ptr_hit = 1'b0;
    end

    assign wr_hit = wr_en_i && (wr_wide_i ? (wr_idx_i[IDX_W-1:1] == (IDX_W-1)'(i / 2))
                                          : (wr_idx_i == IDX_W'(i)));

    // later assignments win: write port > pointer update > mapped write
    always_comb begin
      d = q;
      if (mm_we_i && mm_idx_i == IDX_W'(i)) d = mm_wdata_i;
      if (ptr_hit) d = ptr_val_i[HALF*DATA_W +: DATA_W];
      if (wr_hit)  d = wr_wide_i ? wr_data_i[HALF*DATA_W +: DATA_W] : wr_data_i[DATA_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign regs_o[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rf_ptr_regfile.sv
module rf_ptr_regfile
  import rf_pkg::*;
#(
  parameter int NUM_REGS     = 32,
  parameter int DATA_W       = 8,
  parameter int PTR_BASE     = 26,
  parameter int NUM_PTRS     = 3,
  parameter int DISP_W       = 6,
  parameter int DISP_MIN_SEL = 1,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int SEL_W       = $clog2(NUM_PTRS + 1),
  localparam int ADDR_W      = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [ADDR_W-1:0] rd_pair_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic              wr_wide_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              ptr_en_i,
  input  logic [SEL_W-1:0]  ptr_sel_i,
  input  logic [1:0]        ptr_mode_i,
  input  logic [DISP_W-1:0] ptr_disp_i,
  output logic [ADDR_W-1:0] ptr_addr_o,
  input  logic              mm_en_i,
  input  logic              mm_we_i,
  input  logic [ADDR_W-1:0] mm_addr_i,
  input  logic [DATA_W-1:0] mm_wdata_i,
  output logic              mm_hit_o,
  output logic [DATA_W-1:0] mm_rdata_o
);
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic [NUM_PTRS*ADDR_W-1:0] ptr_vals;
  logic                       ptr_upd;
  logic [SEL_W-1:0]           ptr_upd_sel;
  logic [ADDR_W-1:0]          ptr_upd_val;
  logic                       mm_we;
  logic [IDX_W-1:0]           mm_idx;
  logic [IDX_W-1:0]           pair_lo, pair_hi;

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptrv
    assign ptr_vals[p*ADDR_W +: ADDR_W] =
      {regs_flat[(PTR_BASE+2*p+1)*DATA_W +: DATA_W], regs_flat[(PTR_BASE+2*p)*DATA_W +: DATA_W]};
  end

  rf_ptr_unit #(
    .ADDR_W(ADDR_W), .NUM_PTRS(NUM_PTRS), .DISP_W(DISP_W), .DISP_MIN_SEL(DISP_MIN_SEL)
  ) u_ptr (
    .ptr_vals_i(ptr_vals),
    .en_i      (ptr_en_i),
    .sel_i     (ptr_sel_i),
    .mode_i    (ptr_mode_e'(ptr_mode_i)),
    .disp_i    (ptr_disp_i),
    .addr_o    (ptr_addr_o),
    .upd_o     (ptr_upd),
    .upd_sel_o (ptr_upd_sel),
    .upd_val_o (ptr_upd_val)
  );

  rf_mmap_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_mmap (
    .en_i  (mm_en_i),
    .we_i  (mm_we_i),
    .addr_i(mm_addr_i),
    .hit_o (mm_hit_o),
    .we_o  (mm_we),
    .idx_o (mm_idx)
  );

  rf_storage #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_BASE(PTR_BASE), .NUM_PTRS(NUM_PTRS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_wide_i (wr_wide_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ptr_upd_i (ptr_upd),
    .ptr_sel_i (ptr_upd_sel),
    .ptr_val_i (ptr_upd_val),
    .mm_we_i   (mm_we),
    .mm_idx_i  (mm_idx),
    .mm_wdata_i(mm_wdata_i),
    .regs_o    (regs_flat)
  );

  assign pair_lo     = {rd_a_idx_i[IDX_W-1:1], 1'b0};
  assign pair_hi     = {rd_a_idx_i[IDX_W-1:1], 1'b1};
  assign rd_a_data_o = regs_flat[rd_a_idx_i*DATA_W +: DATA_W];
  assign rd_b_data_o = regs_flat[rd_b_idx_i*DATA_W +: DATA_W];
  assign rd_pair_o   = {regs_flat[pair_hi*DATA_W +: DATA_W], regs_flat[pair_lo*DATA_W +: DATA_W]};
  assign mm_rdata_o  = mm_hit_o ? regs_flat[mm_idx*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/rf_ptr_regfile_chk.sv
module rf_ptr_regfile_chk #(
  parameter int NUM_REGS     = 32,
  parameter int DATA_W       = 8,
  parameter int PTR_BASE     = 26,
  parameter int NUM_PTRS     = 3,
  parameter int DISP_W       = 6,
  parameter int DISP_MIN_SEL = 1,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int SEL_W       = $clog2(NUM_PTRS + 1),
  localparam int ADDR_W      = 2 * DATA_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic                       wr_wide_i,
  input logic [IDX_W-1:0]           wr_idx_i,
  input logic [ADDR_W-1:0]          wr_data_i,
  input logic                       ptr_en_i,
  input logic [SEL_W-1:0]           ptr_sel_i,
  input logic [1:0]                 ptr_mode_i,
  input logic [DISP_W-1:0]          ptr_disp_i,
  input logic [ADDR_W-1:0]          ptr_addr_o,
  input logic                       mm_en_i,
  input logic                       mm_we_i,
  input logic [ADDR_W-1:0]          mm_addr_i,
  input logic [DATA_W-1:0]          mm_wdata_i,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic seen_q;
  logic quiet, valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  function automatic logic [ADDR_W-1:0] pair_of(input logic [NUM_REGS*DATA_W-1:0] f,
                                                input logic [SEL_W-1:0] s);
    return {f[(PTR_BASE+2*s+1)*DATA_W +: DATA_W], f[(PTR_BASE+2*s)*DATA_W +: DATA_W]};
  endfunction

  assign quiet = !wr_en_i && !(mm_en_i && mm_we_i);
  assign valid = ptr_sel_i < SEL_W'(NUM_PTRS);

  a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> regs_flat == '0);

  a_r3_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_wide_i |=>
      regs_flat[$past(wr_idx_i)*DATA_W +: DATA_W] == $past(wr_data_i[DATA_W-1:0]));

  a_r4_pair_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_wide_i |=>
      {regs_flat[{$past(wr_idx_i[IDX_W-1:1]), 1'b1}*DATA_W +: DATA_W],
       regs_flat[{$past(wr_idx_i[IDX_W-1:1]), 1'b0}*DATA_W +: DATA_W]} == $past(wr_data_i));

  a_r5_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |-> ptr_addr_o == '0);

  a_r6_postinc_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && ptr_mode_i == 2'd1 |-> ptr_addr_o == pair_of(regs_flat, ptr_sel_i));

  a_r6_postinc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && ptr_en_i && valid && ptr_mode_i == 2'd1 |=>
      pair_of(regs_flat, $past(ptr_sel_i)) == $past(ptr_addr_o) + ADDR_W'(1));

  a_r7_predec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && ptr_en_i && valid && ptr_mode_i == 2'd2 |=>
      pair_of(regs_flat, $past(ptr_sel_i)) == $past(ptr_addr_o));

  a_r8_disp_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && ptr_mode_i == 2'd3 && ptr_sel_i >= SEL_W'(DISP_MIN_SEL) |->
      ptr_addr_o == pair_of(regs_flat, ptr_sel_i) + ADDR_W'(ptr_disp_i));

  a_r8_disp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && valid && ptr_mode_i == 2'd3 |=>
      pair_of(regs_flat, $past(ptr_sel_i)) == $past(pair_of(regs_flat, ptr_sel_i)));

  a_r9_mapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_en_i && mm_we_i && mm_addr_i < ADDR_W'(NUM_REGS) && !wr_en_i && !ptr_en_i |=>
      regs_flat[$past(mm_addr_i[IDX_W-1:0])*DATA_W +: DATA_W] == $past(mm_wdata_i));
endmodule

bind rf_ptr_regfile rf_ptr_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_BASE(PTR_BASE), .NUM_PTRS(NUM_PTRS),
  .DISP_W(DISP_W), .DISP_MIN_SEL(DISP_MIN_SEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_wide_i(wr_wide_i),
  .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .ptr_en_i(ptr_en_i), .ptr_sel_i(ptr_sel_i),
  .ptr_mode_i(ptr_mode_i), .ptr_disp_i(ptr_disp_i), .ptr_addr_o(ptr_addr_o),
  .mm_en_i(mm_en_i), .mm_we_i(mm_we_i), .mm_addr_i(mm_addr_i), .mm_wdata_i(mm_wdata_i),
  .regs_flat(regs_flat)
);

// File: tb/rf_ptr_regfile_test.sv
`timescale 1ns/1ps
module rf_ptr_regfile_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [7:0]  rd_a_data_o, rd_b_data_o, mm_wdata_i, mm_rdata_o;
  logic [15:0] rd_pair_o, wr_data_i, ptr_addr_o, mm_addr_i;
  logic        wr_en_i, wr_wide_i, ptr_en_i, mm_en_i, mm_we_i, mm_hit_o;
  logic [1:0]  ptr_sel_i, ptr_mode_i;
  logic [5:0]  ptr_disp_i;

  int m[32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  rf_ptr_regfile uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pval(int s);
    return m[26+2*s] + 256 * m[27+2*s];
  endfunction

  function automatic int exp_addr();
    int s = ptr_sel_i, p;
    if (s > 2) return 0;
    p = pval(s);
    case (ptr_mode_i)
      2'd2:    return (p - 1) & 'hFFFF;
      2'd3:    return (s == 0) ? p : ((p + ptr_disp_i) & 'hFFFF);
      default: return p;
    endcase
  endfunction

  task automatic idle();
    rd_a_idx_i = 0; rd_b_idx_i = 0; wr_en_i = 0; wr_wide_i = 0; wr_idx_i = 0; wr_data_i = 0;
    ptr_en_i = 0; ptr_sel_i = 3; ptr_mode_i = 0; ptr_disp_i = 0;
    mm_en_i = 0; mm_we_i = 0; mm_addr_i = 0; mm_wdata_i = 0;
  endtask

  // compare outputs against model, clock, then update model
  task automatic tick();
    int nm[32];
    string preq;
    int a, b, hit;
    #0.5;
    a = rd_a_idx_i; b = rd_b_idx_i;
    chk("R2 read a", rd_a_data_o, m[a]);
    chk("R2 read b", rd_b_data_o, m[b]);
    chk("R2 pair", rd_pair_o, m[a & 30] + 256 * m[a | 1]);
    preq = (ptr_sel_i == 3) ? "R5 addr" : (ptr_mode_i == 1) ? "R6 addr" :
           (ptr_mode_i == 2) ? "R7 addr" : "R8 addr";
    chk(preq, ptr_addr_o, exp_addr());
    hit = (mm_en_i && mm_addr_i < 32) ? 1 : 0;
    chk("R9 hit", mm_hit_o, hit);
    chk("R9 rdata", mm_rdata_o, hit ? m[mm_addr_i[4:0]] : 0);
    nm = m;
    if (mm_en_i && mm_we_i && mm_addr_i < 32) nm[mm_addr_i[4:0]] = mm_wdata_i;
    if (ptr_en_i && ptr_sel_i < 3 && (ptr_mode_i == 1 || ptr_mode_i == 2)) begin
      int s = ptr_sel_i;
      int v = (ptr_mode_i == 1) ? (pval(s) + 1) & 'hFFFF : (pval(s) - 1) & 'hFFFF;
      nm[26+2*s] = v & 255; nm[27+2*s] = v >> 8;
    end
    if (wr_en_i) begin
      if (wr_wide_i) begin
        nm[wr_idx_i & 30] = wr_data_i & 255; nm[wr_idx_i | 1] = wr_data_i >> 8;
      end else nm[wr_idx_i] = wr_data_i & 255;
    end
    @(posedge clk_i);
    m = nm;
    @(negedge clk_i);
    idle();
  endtask

  task automatic expect_reg(string req, int idx, int val);
    idle();
    rd_a_idx_i = 5'(idx);
    #0.5;
    chk(req, rd_a_data_o, val);
    tick();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    foreach (m[i]) m[i] = 0;
    #7 rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 32; i++) expect_reg("R1 reset", i, 0);

    wr_en_i = 1; wr_idx_i = 5; wr_data_i = 16'h00A5; tick();
    expect_reg("R3 byte", 5, 'hA5);

    wr_en_i = 1; wr_wide_i = 1; wr_idx_i = 7; wr_data_i = 16'h1234; tick();
    expect_reg("R4 low", 6, 'h34);
    expect_reg("R4 high", 7, 'h12);

    // read-before-write within one cycle
    rd_a_idx_i = 5; wr_en_i = 1; wr_idx_i = 5; wr_data_i = 16'h0011;
    #0.5 chk("R2 old value", rd_a_data_o, 'hA5);
    tick();
    expect_reg("R3 rewrite", 5, 'h11);

    wr_en_i = 1; wr_wide_i = 1; wr_idx_i = 26; wr_data_i = 16'hFFFF; tick();
    ptr_en_i = 1; ptr_sel_i = 0; ptr_mode_i = 1; tick();
    expect_reg("R6 wrap low", 26, 0);
    expect_reg("R6 wrap high", 27, 0);

    ptr_en_i = 1; ptr_sel_i = 0; ptr_mode_i = 2;
    #0.5 chk("R7 addr wrap", ptr_addr_o, 'hFFFF);
    tick();
    expect_reg("R7 wrap", 27, 'hFF);

    wr_en_i = 1; wr_wide_i = 1; wr_idx_i = 28; wr_data_i = 16'hFFF0; tick();
    ptr_en_i = 1; ptr_sel_i = 1; ptr_mode_i = 3; ptr_disp_i = 6'd63;
    #0.5 chk("R8 disp wrap", ptr_addr_o, 'h002F);
    tick();
    expect_reg("R8 no update", 28, 'hF0);
    ptr_sel_i = 0; ptr_mode_i = 3; ptr_disp_i = 6'd5;
    #0.5 chk("R8 X ignores disp", ptr_addr_o, 'hFFFF);
    tick();

    ptr_en_i = 1; ptr_sel_i = 3; ptr_mode_i = 1;
    #0.5 chk("R5 none addr", ptr_addr_o, 0);
    tick();
    expect_reg("R5 none update", 26, 'hFF);

    mm_en_i = 1; mm_we_i = 1; mm_addr_i = 16'h0003; mm_wdata_i = 8'h3C; tick();
    expect_reg("R9 mapped write", 3, 'h3C);
    mm_en_i = 1; mm_we_i = 1; mm_addr_i = 16'h0020; mm_wdata_i = 8'h77;
    #0.5 chk("R9 miss hit", mm_hit_o, 0);
    chk("R9 miss rdata", mm_rdata_o, 0);
    tick();
    expect_reg("R9 miss no write", 0, 0);

    wr_en_i = 1; wr_wide_i = 1; wr_idx_i = 30; wr_data_i = 16'h5555;
    ptr_en_i = 1; ptr_sel_i = 2; ptr_mode_i = 1; tick();
    expect_reg("R10 write over ptr", 30, 'h55);
    ptr_en_i = 1; ptr_sel_i = 2; ptr_mode_i = 1;
    mm_en_i = 1; mm_we_i = 1; mm_addr_i = 16'd30; mm_wdata_i = 8'h11; tick();
    expect_reg("R10 ptr over mapped", 30, 'h56);

    for (int k = 0; k < 4000; k++) begin
      rd_a_idx_i = 5'($urandom); rd_b_idx_i = 5'($urandom);
      wr_en_i = ($urandom % 3) == 0; wr_wide_i = $urandom % 2;
      wr_idx_i = ($urandom % 2) ? 5'(24 + $urandom % 8) : 5'($urandom);
      wr_data_i = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      ptr_en_i = $urandom % 2; ptr_sel_i = 2'($urandom); ptr_mode_i = 2'($urandom);
      ptr_disp_i = 6'($urandom);
      mm_en_i = $urandom % 2; mm_we_i = $urandom % 2;
      mm_addr_i = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 40);
      mm_wdata_i = 8'($urandom);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule